// File: doc/BRIEF.md
# Block Load Request Sequencer

This block sits on the transmit side of a mirror-array data path. It turns one start command into a whole block load. First it sends a control word that names the load type and the row count. Next it streams the rows across four parallel valid/ready lanes. It then raises a load request and holds it until the receiver reports, on an active-low busy input, that the load has begun. The block accepts no further command until busy has gone high again.

The request may not rise before a fixed setup window has passed. The window protects against the latency of the link, and it is stated in picoseconds and turned into a whole number of clock cycles. For a block that carries data, the window is measured from the first cycle in which data valid is high. For a clear or set operation, which carries no rows, it is measured from the control-word beat. On a short block the timer decides when the request rises. On a long block the end of the transfer decides.

Top module: `blk_load_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of a transfer, `idle_o` is 1 while `load_req_o`, `ctl_valid_o` and every bit of `lane_valid_o` are 0.
- R2: A start command is taken in a cycle with `start_valid_i` high and `idle_o` high. From the next cycle `idle_o` is 0 and `ctl_valid_o` is 1. `ctl_word_o` then carries the load type in its upper 3 bits and the row count in its lower ROW_W bits.
- R3: While `ctl_valid_o` is high and `ctl_ready_i` is low, the control word stays valid and does not change.
- R4: Row r of a block goes out on lane r mod NUM_LANES. The lane's row index field is `lane_row_o[lane*ROW_W +: ROW_W]`, and it equals r during that beat. Each lane sends its rows in ascending order and sends exactly its share of the row count. A valid row stays valid and unchanged until it is accepted.
- R5: Load type 3'b001 (clear), load type 3'b010 (set) and a row count of 0 skip the data phase. In these cases no lane valid is raised.
- R6: When the data transfer ends early, `load_req_o` rises exactly SETUP_CYC cycles after the first data-valid cycle. SETUP_CYC = max(2, ceil(SETUP_PS / CLK_PERIOD_PS)).
- R7: When the last data beat falls in or after cycle SETUP_CYC-1 counted from the first data-valid cycle, `load_req_o` rises in the cycle after that last beat.
- R8: For a load with no data, `load_req_o` rises exactly SETUP_CYC cycles after the cycle of the control-word handshake.
- R9: `load_req_o` stays high while `load_busy_n_i` is high. It falls in the cycle after the first cycle in which `load_busy_n_i` is low.
- R10: After the request is dropped, `idle_o` stays 0 and no command is accepted while `load_busy_n_i` is low. `idle_o` returns to 1 in the cycle after `load_busy_n_i` goes high.
- R11: `load_req_o` is never high in a cycle in which `ctl_valid_o` or any lane valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_valid_i | input | 1 | Start command present |
| start_type_i | input | 3 | Load type of the command |
| start_rows_i | input | ROW_W | Row count of the command |
| idle_o | output | 1 | Ready to accept a command |
| ctl_valid_o | output | 1 | Control word valid |
| ctl_ready_i | input | 1 | Control word accepted |
| ctl_word_o | output | 3+ROW_W | Load type and row count |
| lane_valid_o | output | NUM_LANES | Per-lane row valid |
| lane_ready_i | input | NUM_LANES | Per-lane row accepted |
| lane_row_o | output | NUM_LANES*ROW_W | Per-lane row index, lane l at bits l*ROW_W |
| load_req_o | output | 1 | Load request to the receiver |
| load_busy_n_i | input | 1 | Receiver load in progress, active low |

## Verification
The end of the data transfer and the end of the setup window can decide the request in the same cycle. The bench provokes this with a clock period that gives SETUP_CYC = 15 and all lanes always ready. It then picks row counts so that the final beat falls before the window expires (3 rows), exactly on the expiry cycle (60 rows), and one cycle after it (64 rows). In each case it compares the cycle in which the request rises with the later of the two limits, computed in the bench. Stalled lanes, delayed control acceptance and loads without data each move one of the two limits on its own.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_DATA,
        ST_WAIT,
        ST_REQ,
        ST_RECOVER
    } seq_state_e;

    localparam logic [2:0] LT_CLEAR = 3'b001;
    localparam logic [2:0] LT_SET   = 3'b010;

    // Load types other than clear and set move row data.
    function automatic logic type_has_rows(input logic [2:0] lt);
        return !((lt == LT_CLEAR) || (lt == LT_SET));
    endfunction

endpackage

// File: rtl/lrs_setup_timer.sv
module lrs_setup_timer #(
    parameter int SETUP_CYC = 60,
    parameter int TMR_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [TMR_W-1:0] load_val_i,
    output logic             elapsed_o
);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q.cnt <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // The window has passed when the next edge ends it.
    assign elapsed_o = (tmr_q.cnt <= TMR_W'(1));

    // R6
    tmr_range_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (tmr_q.cnt <= TMR_W'(SETUP_CYC)));

endmodule

// File: rtl/lrs_lane.sv
module lrs_lane #(
    parameter int ROW_W     = 8,
    parameter int NUM_LANES = 4,
    parameter int LANE_IDX  = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic [ROW_W-1:0] rows_i,
    input  logic             run_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [ROW_W-1:0] row_o,
    output logic             fin_o
);

    typedef struct packed {
        logic [ROW_W-1:0] total;
        logic [ROW_W-1:0] sent;
    } lane_t;

    lane_t ln_d, ln_q;
    logic  beat;
    logic [ROW_W-1:0] share;

    always_comb begin
        share = ROW_W'(32'(rows_i) / NUM_LANES)
              + ROW_W'((32'(rows_i) % NUM_LANES) > LANE_IDX);
    end

    assign valid_o = run_i && (ln_q.sent != ln_q.total);
    assign beat    = valid_o && ready_i;
    assign row_o   = ROW_W'(32'(ln_q.sent) * NUM_LANES + LANE_IDX);
    assign fin_o   = (ln_q.sent == ln_q.total)
                  || (beat && ((ln_q.sent + ROW_W'(1)) == ln_q.total));

    always_comb begin
        ln_d = ln_q;
        if (arm_i) begin
            ln_d.total = share;
            ln_d.sent  = '0;
        end else if (beat) begin
            ln_d.sent = ln_q.sent + ROW_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ln_q.total <= '0;
            ln_q.sent  <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    // R4
    lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ready_i) |=> (valid_o && $stable(row_o)));

    // R4
    lane_no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (ln_q.sent <= ln_q.total));

endmodule

// File: rtl/lrs_seq_fsm.sv
module lrs_seq_fsm
    import lrs_pkg::*;
#(
    parameter int ROW_W     = 8,
    parameter int SETUP_CYC = 60,
    parameter int TMR_W     = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_valid_i,
    input  logic [2:0]         start_type_i,
    input  logic [ROW_W-1:0]   start_rows_i,
    input  logic               ctl_ready_i,
    input  logic               all_fin_i,
    input  logic               setup_ok_i,
    input  logic               load_busy_n_i,
    output logic               idle_o,
    output logic               ctl_valid_o,
    output logic [ROW_W+2:0]   ctl_word_o,
    output logic               arm_o,
    output logic               run_o,
    output logic               tmr_load_o,
    output logic [TMR_W-1:0]   tmr_val_o,
    output logic               load_req_o
);

    typedef struct packed {
        seq_state_e       state;
        logic [2:0]       ltype;
        logic [ROW_W-1:0] rows;
    } seq_t;

    seq_t sq_d, sq_q;
    logic needs_rows;

    assign needs_rows = type_has_rows(sq_q.ltype) && (sq_q.rows != '0);

    always_comb begin
        sq_d       = sq_q;
        arm_o      = 1'b0;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        case (sq_q.state)
            ST_IDLE: begin
                if (start_valid_i) begin
                    sq_d.state = ST_CTRL;
                    sq_d.ltype = start_type_i;
                    sq_d.rows  = start_rows_i;
                    arm_o      = 1'b1;
                end
            end
            ST_CTRL: begin
                if (ctl_ready_i) begin
                    tmr_load_o = 1'b1;
                    if (needs_rows) begin
                        // first valid is one cycle later: one extra count
                        tmr_val_o  = TMR_W'(SETUP_CYC);
                        sq_d.state = ST_DATA;
                    end else begin
                        tmr_val_o  = TMR_W'(SETUP_CYC - 1);
                        sq_d.state = ST_WAIT;
                    end
                end
            end
            ST_DATA: begin
                if (all_fin_i) begin
                    sq_d.state = setup_ok_i ? ST_REQ : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (setup_ok_i) begin
                    sq_d.state = ST_REQ;
                end
            end
            ST_REQ: begin
                if (!load_busy_n_i) begin
                    sq_d.state = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (load_busy_n_i) begin
                    sq_d.state = ST_IDLE;
                end
            end
            default: sq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q.state <= ST_IDLE;
            sq_q.ltype <= '0;
            sq_q.rows  <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign idle_o      = (sq_q.state == ST_IDLE);
    assign ctl_valid_o = (sq_q.state == ST_CTRL);
    assign ctl_word_o  = {sq_q.ltype, sq_q.rows};
    assign run_o       = (sq_q.state == ST_DATA);
    assign load_req_o  = (sq_q.state == ST_REQ);

    // R3
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_valid_o && !ctl_ready_i) |=> (ctl_valid_o && $stable(ctl_word_o)));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (load_req_o && load_busy_n_i) |=> load_req_o);

    // R10
    idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_o) |-> $past(load_busy_n_i));

endmodule

// File: rtl/blk_load_seq.sv
module blk_load_seq #(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int SETUP_PS      = 300000,
    parameter int NUM_LANES     = 4,
    parameter int ROW_W         = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_valid_i,
    input  logic [2:0]                 start_type_i,
    input  logic [ROW_W-1:0]           start_rows_i,
    output logic                       idle_o,
    output logic                       ctl_valid_o,
    input  logic                       ctl_ready_i,
    output logic [ROW_W+2:0]           ctl_word_o,
    output logic [NUM_LANES-1:0]       lane_valid_o,
    input  logic [NUM_LANES-1:0]       lane_ready_i,
    output logic [NUM_LANES*ROW_W-1:0] lane_row_o,
    output logic                       load_req_o,
    input  logic                       load_busy_n_i
);

    localparam int SETUP_RAW = (SETUP_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int SETUP_CYC = (SETUP_RAW < 2) ? 2 : SETUP_RAW;
    localparam int TMR_W     = $clog2(SETUP_CYC + 1);

    logic             arm, run, tmr_load, setup_ok, all_fin;
    logic [TMR_W-1:0] tmr_val;
    logic [NUM_LANES-1:0] lane_fin;

    assign all_fin = &lane_fin;

    lrs_seq_fsm #(
        .ROW_W     (ROW_W),
        .SETUP_CYC (SETUP_CYC),
        .TMR_W     (TMR_W)
    ) i_fsm (
        .clk           (clk),
        .rst           (rst),
        .start_valid_i (start_valid_i),
        .start_type_i  (start_type_i),
        .start_rows_i  (start_rows_i),
        .ctl_ready_i   (ctl_ready_i),
        .all_fin_i     (all_fin),
        .setup_ok_i    (setup_ok),
        .load_busy_n_i (load_busy_n_i),
        .idle_o        (idle_o),
        .ctl_valid_o   (ctl_valid_o),
        .ctl_word_o    (ctl_word_o),
        .arm_o         (arm),
        .run_o         (run),
        .tmr_load_o    (tmr_load),
        .tmr_val_o     (tmr_val),
        .load_req_o    (load_req_o)
    );

    lrs_setup_timer #(
        .SETUP_CYC (SETUP_CYC),
        .TMR_W     (TMR_W)
    ) i_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .elapsed_o  (setup_ok)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        lrs_lane #(
            .ROW_W     (ROW_W),
            .NUM_LANES (NUM_LANES),
            .LANE_IDX  (l)
        ) i_lane (
            .clk     (clk),
            .rst     (rst),
            .arm_i   (arm),
            .rows_i  (start_rows_i),
            .run_i   (run),
            .ready_i (lane_ready_i[l]),
            .valid_o (lane_valid_o[l]),
            .row_o   (lane_row_o[l*ROW_W +: ROW_W]),
            .fin_o   (lane_fin[l])
        );
    end

    // R6
    req_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
        load_req_o |-> setup_ok);

    // R11
    req_excl_chk: assert property (@(posedge clk) disable iff (rst)
        load_req_o |-> (!ctl_valid_o && (lane_valid_o == '0)));

endmodule

// File: tb/test_blk_load_seq.sv
module test_blk_load_seq;

    localparam int CLK_NS = 20;
    localparam int NL     = 4;
    localparam int RW     = 8;
    localparam int SETUP  = (300 + CLK_NS - 1) / CLK_NS;

    typedef struct packed {
        logic [2:0]    lt;
        logic [RW-1:0] rows;
        logic          stall;
        logic [3:0]    cdly;
        logic [3:0]    lag;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'b000, 8'd3,  1'b0, 4'd0, 4'd0},
        '{3'b011, 8'd60, 1'b0, 4'd0, 4'd1},
        '{3'b100, 8'd64, 1'b0, 4'd0, 4'd0},
        '{3'b001, 8'd10, 1'b0, 4'd1, 4'd0},
        '{3'b010, 8'd0,  1'b0, 4'd0, 4'd2},
        '{3'b000, 8'd0,  1'b0, 4'd0, 4'd0},
        '{3'b111, 8'd37, 1'b1, 4'd3, 4'd0},
        '{3'b101, 8'd5,  1'b1, 4'd1, 4'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_valid = 1'b0;
    logic [2:0] start_type = '0;
    logic [RW-1:0] start_rows = '0;
    logic idle, ctl_valid, load_req;
    logic ctl_ready = 1'b0;
    logic [RW+2:0] ctl_word;
    logic [NL-1:0] lane_valid;
    logic [NL-1:0] lane_ready = '0;
    logic [NL*RW-1:0] lane_row;
    logic busy_n = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    blk_load_seq #(
        .CLK_PERIOD_PS (CLK_NS * 1000),
        .SETUP_PS      (300000),
        .NUM_LANES     (NL),
        .ROW_W         (RW)
    ) i_blk_load_seq (
        .clk           (clk),
        .rst           (rst),
        .start_valid_i (start_valid),
        .start_type_i  (start_type),
        .start_rows_i  (start_rows),
        .idle_o        (idle),
        .ctl_valid_o   (ctl_valid),
        .ctl_ready_i   (ctl_ready),
        .ctl_word_o    (ctl_word),
        .lane_valid_o  (lane_valid),
        .lane_ready_i  (lane_ready),
        .lane_row_o    (lane_row),
        .load_req_o    (load_req),
        .load_busy_n_i (busy_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R11: request never overlaps any valid
    always @(negedge clk) begin
        if (!rst && load_req) begin
            chk(!ctl_valid && (lane_valid == '0), "R11", int'(lane_valid), 0);
        end
    end

    function automatic int share(input int rows, input int l);
        return rows / NL + ((l < rows % NL) ? 1 : 0);
    endfunction

    task automatic run_vec(input vec_t v);
        int sent [NL];
        int last_beat;
        int req_at;
        int exp_at;
        bit has_rows;
        for (int l = 0; l < NL; l++) sent[l] = 0;
        last_beat = 0;
        req_at    = -1;
        has_rows  = !((v.lt == 3'b001) || (v.lt == 3'b010)) && (v.rows != 0);
        for (int w = 0; w < 50 && !idle; w++) @(negedge clk);
        start_valid = 1'b1;
        start_type  = v.lt;
        start_rows  = v.rows;
        @(negedge clk);
        start_valid = 1'b0;
        chk(!idle && ctl_valid, "R2", int'({idle, ctl_valid}), 1);
        chk(ctl_word == {v.lt, v.rows}, "R2", int'(ctl_word), int'({v.lt, v.rows}));
        for (int i = 0; i < int'(v.cdly); i++) begin
            @(negedge clk);
            chk(ctl_valid && (ctl_word == {v.lt, v.rows}), "R3", int'(ctl_word),
                int'({v.lt, v.rows}));
        end
        ctl_ready = 1'b1;
        for (int k = 1; k < 400; k++) begin
            @(negedge clk);
            ctl_ready = 1'b0;
            if (load_req) begin
                req_at = k;
                break;
            end
            for (int l = 0; l < NL; l++) begin
                lane_ready[l] = v.stall ? (((k + l) % 3) != 0) : 1'b1;
                if (lane_valid[l] && lane_ready[l]) begin
                    chk(lane_row[l*RW +: RW] == RW'(sent[l] * NL + l), "R4",
                        int'(lane_row[l*RW +: RW]), sent[l] * NL + l);
                    sent[l]++;
                    last_beat = k;
                end
            end
        end
        lane_ready = '0;
        for (int l = 0; l < NL; l++) begin
            if (has_rows)
                chk(sent[l] == share(int'(v.rows), l), "R4", sent[l], share(int'(v.rows), l));
            else
                chk(sent[l] == 0, "R5", sent[l], 0);
        end
        if (has_rows) begin
            exp_at = (last_beat + 1 > SETUP + 1) ? last_beat + 1 : SETUP + 1;
            chk(req_at == exp_at, (last_beat + 1 > SETUP + 1) ? "R7" : "R6", req_at, exp_at);
        end else begin
            chk(req_at == SETUP, "R8", req_at, SETUP);
        end
        for (int i = 0; i < int'(v.lag); i++) begin
            @(negedge clk);
            chk(load_req, "R9", int'(load_req), 1);
        end
        busy_n = 1'b0;
        @(negedge clk);
        chk(!load_req, "R9", int'(load_req), 0);
        start_valid = 1'b1;
        start_type  = 3'b000;
        start_rows  = 8'd1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!idle && !ctl_valid, "R10", int'({idle, ctl_valid}), 0);
        end
        busy_n      = 1'b1;
        start_valid = 1'b0;
        @(negedge clk);
        chk(idle && !ctl_valid, "R10", int'(idle), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(idle && !load_req && !ctl_valid && (lane_valid == '0), "R1",
            int'({idle, load_req, ctl_valid}), 4);
        rst = 1'b0;
        @(negedge clk);
        chk(idle && !load_req && !ctl_valid, "R1", int'({idle, load_req, ctl_valid}), 4);

        for (int n = 0; n < NV; n++) begin
            run_vec(VECS[n]);
        end

        // R1: reset in the middle of a data phase
        start_valid = 1'b1;
        start_type  = 3'b000;
        start_rows  = 8'd40;
        @(negedge clk);
        start_valid = 1'b0;
        ctl_ready   = 1'b1;
        @(negedge clk);
        ctl_ready = 1'b0;
        @(negedge clk);
        chk(lane_valid == '1, "R4", int'(lane_valid), 15);
        rst = 1'b1;
        @(negedge clk);
        chk(idle && !load_req && !ctl_valid && (lane_valid == '0), "R1",
            int'({idle, load_req, ctl_valid, lane_valid}), 64);
        rst = 1'b0;
        @(negedge clk);
        chk(idle && (lane_valid == '0), "R1", int'(lane_valid), 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule